// File: doc/BRIEF.md
# Status Byte and Service Request Summary

This block forms an 8-bit status byte out of five live summary flags. Three come from upstream event register sets: operational, questionable and standard event. The other two come from the output buffer (data pending) and the error queue (not empty). The byte is not latched. Every summary bit follows its source input directly. When an upstream set is cleared, or its queue drains, the matching bit drops in the same cycle.

A programmable service request mask selects which summary bits may raise the master summary bit. The master bit is computed again every cycle from the masked summaries. Reading the status byte therefore never disturbs it. The master bit falls only when the cause is removed at its source or the matching mask bit is cleared. The mask register is the only storage in the block. It has a write port and a read port. A clear-status strobe is passed straight through to the upstream register sets.

Top module: `stb_srq_core`

## Requirements
- R1: Status byte bit positions: bit 7 = operation summary, bit 5 = standard event summary, bit 4 = message available, bit 3 = questionable summary, bit 2 = error available, bit 6 = master summary.
- R2: Bits 1 and 0 of the status byte always read as zero.
- R3: Summary bits are not latched: each bit equals its source input in the same cycle, so deasserting a source clears the bit immediately.
- R4: The master bit is 1 exactly when some summary bit (7,5,4,3,2) is 1 and the matching mask bit is 1.
- R5: Mask bit 6 has no effect on the master bit.
- R6: Reading the status byte (asserting `stb_rd`) does not change the master bit or any other status bit.
- R7: The mask register resets to 0x00. A write with `sre_we` high stores `sre_wdata` at the next clock edge, and `sre_rdata` returns the stored value.
- R8: `stb_rdata` is valid combinationally in the same cycle as `stb_rd` and reads 0x00 when `stb_rd` is low.
- R9: `cls_out` equals `cls_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oper_sum | input | 1 | Operational set summary |
| std_sum | input | 1 | Standard event set summary |
| ques_sum | input | 1 | Questionable set summary |
| obuf_pend | input | 1 | Output buffer holds unread data |
| errq_pend | input | 1 | Error queue is non-empty |
| sre_we | input | 1 | Mask register write strobe |
| sre_wdata | input | 8 | Mask write data |
| sre_rdata | output | 8 | Mask register contents |
| stb_rd | input | 1 | Status byte read request |
| stb_rdata | output | 8 | Status byte, gated by read request |
| cls_in | input | 1 | Clear-status strobe from the command side |
| cls_out | output | 1 | Clear-status strobe to the upstream sets |
| srq | output | 1 | Master summary bit, always visible |

## Verification
Each source is first driven alone, which confirms the bit positions and shows that nothing is latched. Then all five sources are driven together and the mask is walked bit by bit. This separates a correct AND-OR master from one that ignores the mask or uses the wrong lane. A mask holding only bit 6, with every source active, exposes any self-feedback of the master bit. Repeated reads with the sources held steady, followed by source removal, separate a read-to-clear implementation from the required live behaviour.

// File: rtl/stb_srq_core.sv
module stb_srq_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oper_sum,
  input  logic         std_sum,
  input  logic         ques_sum,
  input  logic         obuf_pend,
  input  logic         errq_pend,
  input  logic         sre_we,
  input  logic [W-1:0] sre_wdata,
  output logic [W-1:0] sre_rdata,
  input  logic         stb_rd,
  output logic [W-1:0] stb_rdata,
  input  logic         cls_in,
  output logic         cls_out,
  output logic         srq
);
  localparam int MSS_BIT = 6;

  logic [W-1:0] mask_q;
  logic [W-1:0] summ;
  logic [W-1:0] status;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else if (sre_we) mask_q <= sre_wdata;

  always_comb begin
    summ    = '0;
    summ[7] = oper_sum;
    summ[5] = std_sum;
    summ[4] = obuf_pend;
    summ[3] = ques_sum;
    summ[2] = errq_pend;
  end

  assign srq       = |(summ & mask_q);
  always_comb begin
    status          = summ;
    status[MSS_BIT] = srq;
  end
  assign stb_rdata = stb_rd ? status : '0;
  assign sre_rdata = mask_q;
  assign cls_out   = cls_in;
endmodule

module stb_srq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       oper_sum,
  input logic       std_sum,
  input logic       ques_sum,
  input logic       obuf_pend,
  input logic       errq_pend,
  input logic       sre_we,
  input logic [7:0] sre_wdata,
  input logic [7:0] sre_rdata,
  input logic       stb_rd,
  input logic [7:0] stb_rdata,
  input logic       cls_in,
  input logic       cls_out,
  input logic       srq
);
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rdata[1:0] == 2'b00);
  a_r3_oper_live: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rd |-> stb_rdata[7] == oper_sum);
  a_r3_errq_live: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rd |-> stb_rdata[2] == errq_pend);
  a_r4_master_cause: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> (oper_sum && sre_rdata[7]) || (std_sum && sre_rdata[5]) ||
            (obuf_pend && sre_rdata[4]) || (ques_sum && sre_rdata[3]) ||
            (errq_pend && sre_rdata[2]));
  a_r5_no_self_feed: assert property (@(posedge clk) disable iff (!rst_n)
    (sre_rdata[7:0] & 8'hBC) == 8'h00 |-> !srq);
  a_r6_read_no_side: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stb_rd) && $stable(sre_rdata) && $stable({oper_sum, std_sum, ques_sum, obuf_pend, errq_pend})) |-> $stable(srq));
  a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    sre_we |=> sre_rdata == $past(sre_wdata));
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rd |-> stb_rdata == 8'h00);
  a_r9_cls_pass: assert property (@(posedge clk) disable iff (!rst_n)
    cls_out == cls_in);
endmodule

bind stb_srq_core stb_srq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oper_sum(oper_sum), .std_sum(std_sum),
  .ques_sum(ques_sum), .obuf_pend(obuf_pend), .errq_pend(errq_pend),
  .sre_we(sre_we), .sre_wdata(sre_wdata), .sre_rdata(sre_rdata),
  .stb_rd(stb_rd), .stb_rdata(stb_rdata), .cls_in(cls_in),
  .cls_out(cls_out), .srq(srq)
);

// File: tb/tb_stb_srq_core.sv
module tb_stb_srq_core;
  logic clk = 0, rst_n = 0;
  logic oper_sum = 0, std_sum = 0, ques_sum = 0, obuf_pend = 0, errq_pend = 0;
  logic sre_we = 0, stb_rd = 0, cls_in = 0;
  logic [7:0] sre_wdata = 0;
  logic [7:0] sre_rdata, stb_rdata;
  logic cls_out, srq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stb_srq_core dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic src(logic [4:0] v);
    @(negedge clk);
    {oper_sum, std_sum, obuf_pend, ques_sum, errq_pend} = v;
    #1;
  endtask

  task automatic wr_mask(logic [7:0] m);
    @(negedge clk);
    sre_we = 1; sre_wdata = m;
    @(negedge clk);
    sre_we = 0;
    #1;
  endtask

  function automatic logic [7:0] model(logic [4:0] v, logic [7:0] m);
    logic [7:0] s;
    s = {v[4], 1'b0, v[3], v[2], v[1], v[0], 2'b00};
    s[6] = |(s & m & 8'hBC);
    return s;
  endfunction

  task automatic t_reset;
    chk("R7 reset mask", sre_rdata, 8'h00);
    stb_rd = 1; #1;
    chk("R2 reset status", stb_rdata, 8'h00);
  endtask

  task automatic t_positions;
    for (int i = 0; i < 5; i++) begin
      src(5'b1 << i);
      chk("R1 single source", stb_rdata, model(5'b1 << i, 8'h00));
    end
    src(5'b0);
    chk("R3 source removed", stb_rdata, 8'h00);
  endtask

  task automatic t_master;
    src(5'h1F);
    for (int b = 2; b < 8; b++) begin
      if (b == 6) continue;
      wr_mask(8'h1 << b);
      chk("R4 master one lane", stb_rdata, model(5'h1F, 8'h1 << b));
      chk("R7 mask readback", sre_rdata, 8'h1 << b);
    end
    wr_mask(8'h20);
    src(5'b01000);
    chk("R4 masked lane source active", {7'b0, srq}, 8'h01);
    src(5'b10111);
    chk("R4 other lanes only", {7'b0, srq}, 8'h00);
    chk("R2 low bits zero", stb_rdata & 8'h03, 8'h00);
  endtask

  task automatic t_self;
    src(5'h1F);
    wr_mask(8'h43);
    chk("R5 mask bit6 ignored", {7'b0, srq}, 8'h00);
  endtask

  task automatic t_read;
    src(5'b00001);
    wr_mask(8'h04);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); stb_rd = ~stb_rd; #1;
      chk("R6 read no clear", {7'b0, srq}, 8'h01);
    end
    stb_rd = 0; #1;
    chk("R8 idle read zero", stb_rdata, 8'h00);
    stb_rd = 1; #1;
    chk("R8 same-cycle read", stb_rdata, 8'h44);
    src(5'b0);
    chk("R3 master clears with source", stb_rdata, 8'h00);
    src(5'b00001);
    wr_mask(8'h00);
    chk("R4 master clears with mask", stb_rdata, 8'h04);
  endtask

  task automatic t_cls;
    cls_in = 1; #1;
    chk("R9 cls high", {7'b0, cls_out}, 8'h01);
    cls_in = 0; #1;
    chk("R9 cls low", {7'b0, cls_out}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_positions();
    t_master();
    t_self();
    t_read();
    t_cls();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule